// File: doc/BRIEF.md
# Programmable Colour Matrix Converter

This block converts the colour space of a video stream one pixel at a time. Each pixel has three 8-bit channels. Each output channel is a weighted sum of the three input channels plus a constant offset. The twelve weights and offsets form one 3x4 affine matrix, so a single block can reorder channels, convert between RGB and luma/chroma forms, or apply a gain and an offset. No output pixel depends on any other pixel.

Pixels enter and leave on AXI4-Stream at one pixel per clock. The start-of-frame flag (TUSER) and the end-of-line flag (TLAST) travel through the block with their pixel. Software writes the coefficients through a small write port into a shadow copy. The shadow copy takes effect at the next start-of-frame pixel, so a frame is never processed with a mix of old and new coefficients. When the downstream side deasserts ready, the whole pipeline holds.

Top module: `color_matrix_xform`

## Requirements
- R1: After reset, m_tvalid_o is low and s_tready_o is high. The active coefficient set is the identity: 1.0 at addresses 0, 4 and 8 and 0.0 at every other address. With this set, every pixel passes through unchanged.
- R2: Channel k (k = 0, 1, 2) occupies data bits [8k+7:8k]. Output channel r equals the sum over k of coefficient[3r+k] times input channel k, plus coefficient[9+r] times 255. Coefficients are signed two's-complement values with 16 fractional bits, written to cfg_addr_i 0 to 11.
- R3: Each channel result is rounded to the nearest integer, and an exact half rounds upward: x.5 becomes x+1.
- R4: A rounded result below 0 becomes 0, and a rounded result above 255 becomes 255.
- R5: A coefficient write changes only the shadow set. The shadow set becomes the active set when a pixel with s_tuser_i high is accepted, and that pixel is already processed with the new set. Pixels accepted before that point use the old set.
- R6: If the output is not stalled, a pixel accepted on a clock edge appears on m_tdata_o after the second following edge. The block has three register stages.
- R7: m_tuser_o and m_tlast_o are delivered with the same pixel that carried them on the input.
- R8: While m_tvalid_o is high and m_tready_i is low, the output data, flags and valid stay unchanged, and s_tready_o is low. No pixel is lost or duplicated.
- R9: Writes to cfg_addr_i values 12 to 15 have no effect on the coefficients.
- R10: Setting 1.0 at addresses 2, 4 and 6 and 0.0 at all other addresses swaps channels 0 and 2 and leaves channel 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_addr_i | input | 4 | Coefficient index: 0..8 matrix, 9..11 offsets |
| cfg_data_i | input | 18 | Signed coefficient, 16 fractional bits |
| s_tdata_i | input | 24 | Input pixel |
| s_tvalid_i | input | 1 | Input valid |
| s_tready_o | output | 1 | Input ready |
| s_tuser_i | input | 1 | Input start of frame |
| s_tlast_i | input | 1 | Input end of line |
| m_tdata_o | output | 24 | Output pixel |
| m_tvalid_o | output | 1 | Output valid |
| m_tready_i | input | 1 | Output ready |
| m_tuser_o | output | 1 | Output start of frame |
| m_tlast_o | output | 1 | Output end of line |

## Verification
Each coefficient set is driven with a 256-pixel sweep in which every channel takes every value from 0 to 255.

- **Identity and swap sets.** These tell apart correct channel placement from crossed rows or columns.
- **Luma/chroma set.** This set has fractional weights, negative weights and offsets, so it exposes errors in sign extension and in offset scaling.
- **Half-weight set.** These weights land exactly on .5 results, which separates round-half-up from truncation and from round-half-down.
- **Large-weight and negative-weight set.** This set drives results into both saturation limits.
- **Shadow and ignored-address tests.** The bench writes a new set or an out-of-range address with no start of frame, then confirms the old result continues.
- **Backpressure.** Random patterns on ready and valid confirm that stalled output is held and that no pixel is lost or repeated.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned NUM_COEF = NUM_CH * NUM_CH + NUM_CH;
  localparam int unsigned BIAS_OFS = NUM_CH * NUM_CH;

  function automatic bit is_diag(input int unsigned idx);
    return (idx < BIAS_OFS) && ((idx / NUM_CH) == (idx % NUM_CH));
  endfunction
endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank
  import cmx_pkg::*;
#(
  parameter int unsigned COEF_W = 18,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [COEF_W-1:0]                  data_i,
  input  logic                               load_i,
  output logic [NUM_COEF-1:0][COEF_W-1:0]    coef_o
);
  localparam logic [COEF_W-1:0] ONE = COEF_W'(1) << FRAC_W;

  logic [NUM_COEF-1:0][COEF_W-1:0] shadow_q, active_q;

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    localparam logic [COEF_W-1:0] RST_VAL = is_diag(i) ? ONE : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i] <= RST_VAL;
      end else if (we_i && (addr_i == ADDR_W'(i))) begin
        shadow_q[i] <= data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_q[i] <= RST_VAL;
      end else if (load_i) begin
        active_q[i] <= shadow_q[i];
      end
    end
  end

  // frame-start pixel already sees the new set
  assign coef_o = load_i ? shadow_q : active_q;
endmodule

// File: rtl/cmx_row_mac.sv
module cmx_row_mac
  import cmx_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned COEF_W = 18,
  parameter int unsigned FRAC_W = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]      pix_i,
  input  logic [NUM_CH-1:0][COEF_W-1:0]    wgt_i,
  input  logic [COEF_W-1:0]                bias_i,
  output logic [CH_W-1:0]                  res_o
);
  localparam int unsigned PROD_W = COEF_W + CH_W + 1;
  localparam int unsigned ACC_W  = PROD_W + 2;
  localparam int unsigned INT_W  = ACC_W - FRAC_W;
  localparam logic signed [PROD_W-1:0] FULL = {{(PROD_W-CH_W){1'b0}}, {CH_W{1'b1}}};
  localparam logic signed [ACC_W-1:0]  HALF =
    {{(ACC_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod_d [NUM_CH+1];
  logic signed [PROD_W-1:0] prod_q [NUM_CH+1];
  logic signed [ACC_W-1:0]  sum_d, sum_q, rnd;
  logic        [INT_W-1:0]  int_part;
  logic        [CH_W-1:0]   sat_d, res_q;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      prod_d[k] = $signed({{(PROD_W-CH_W){1'b0}}, pix_i[k]}) *
                  $signed({{(PROD_W-COEF_W){wgt_i[k][COEF_W-1]}}, wgt_i[k]});
    end
    prod_d[NUM_CH] = $signed({{(PROD_W-COEF_W){bias_i[COEF_W-1]}}, bias_i}) * FULL;
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k <= NUM_CH; k++) begin
      sum_d = sum_d + $signed({{(ACC_W-PROD_W){prod_q[k][PROD_W-1]}}, prod_q[k]});
    end
  end

  always_comb begin
    rnd      = sum_q + HALF;
    int_part = rnd[ACC_W-1:FRAC_W];
    if (int_part[INT_W-1])            sat_d = '0;
    else if (|int_part[INT_W-2:CH_W]) sat_d = '1;
    else                              sat_d = int_part[CH_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= NUM_CH; k++) prod_q[k] <= '0;
      sum_q <= '0;
      res_q <= '0;
    end else if (en_i) begin
      for (int k = 0; k <= NUM_CH; k++) prod_q[k] <= prod_d[k];
      sum_q <= sum_d;
      res_q <= sat_d;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/cmx_stream_ctrl.sv
module cmx_stream_ctrl #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_valid_i,
  input  logic s_user_i,
  input  logic s_last_i,
  input  logic m_ready_i,
  output logic en_o,
  output logic m_valid_o,
  output logic m_user_o,
  output logic m_last_o
);
  logic [DEPTH-1:0] vld_q, usr_q, lst_q;

  // global stall: bubbles are not squeezed out
  assign en_o = !vld_q[DEPTH-1] || m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      usr_q <= '0;
      lst_q <= '0;
    end else if (en_o) begin
      vld_q <= {vld_q[DEPTH-2:0], s_valid_i};
      usr_q <= {usr_q[DEPTH-2:0], s_user_i};
      lst_q <= {lst_q[DEPTH-2:0], s_last_i};
    end
  end

  assign m_valid_o = vld_q[DEPTH-1];
  assign m_user_o  = usr_q[DEPTH-1];
  assign m_last_o  = lst_q[DEPTH-1];
endmodule

// File: rtl/color_matrix_xform.sv
module color_matrix_xform
  import cmx_pkg::*;
#(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned COEF_W = 18,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned ADDR_W = $clog2(NUM_COEF),
  parameter int unsigned PIX_W  = NUM_CH * CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [COEF_W-1:0] cfg_data_i,
  input  logic [PIX_W-1:0]  s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  input  logic              s_tuser_i,
  input  logic              s_tlast_i,
  output logic [PIX_W-1:0]  m_tdata_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i,
  output logic              m_tuser_o,
  output logic              m_tlast_o
);
  localparam int unsigned STAGES = 3;

  logic                              en;
  logic                              sof_acc;
  logic [NUM_COEF-1:0][COEF_W-1:0]   coef;
  logic [NUM_CH-1:0][CH_W-1:0]       pix;

  assign s_tready_o = en;
  assign sof_acc    = s_tvalid_i && en && s_tuser_i;
  assign pix        = s_tdata_i;

  cmx_coef_bank #(
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .load_i (sof_acc),
    .coef_o (coef)
  );

  cmx_stream_ctrl #(
    .DEPTH (STAGES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_valid_i (s_tvalid_i),
    .s_user_i  (s_tuser_i),
    .s_last_i  (s_tlast_i),
    .m_ready_i (m_tready_i),
    .en_o      (en),
    .m_valid_o (m_tvalid_o),
    .m_user_o  (m_tuser_o),
    .m_last_o  (m_tlast_o)
  );

  for (genvar r = 0; r < NUM_CH; r++) begin : g_row
    logic [NUM_CH-1:0][COEF_W-1:0] wgt;
    for (genvar k = 0; k < NUM_CH; k++) begin : g_w
      assign wgt[k] = coef[r*NUM_CH+k];
    end

    cmx_row_mac #(
      .CH_W   (CH_W),
      .COEF_W (COEF_W),
      .FRAC_W (FRAC_W)
    ) u_mac (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en),
      .pix_i  (pix),
      .wgt_i  (wgt),
      .bias_i (coef[BIAS_OFS+r]),
      .res_o  (m_tdata_o[r*CH_W +: CH_W])
    );
  end
endmodule

// File: rtl/cmx_chk.sv
module cmx_chk #(
  parameter int unsigned PIX_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_tvalid_i,
  input logic             s_tready_o,
  input logic [PIX_W-1:0] m_tdata_o,
  input logic             m_tvalid_o,
  input logic             m_tready_i,
  input logic             m_tuser_o,
  input logic             m_tlast_o
);
  logic [2:0] inflight_q;
  logic       acc, dlv;

  assign acc = s_tvalid_i && s_tready_o;
  assign dlv = m_tvalid_o && m_tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + 3'(acc) - 3'(dlv);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) $rose(rst_ni) |-> !m_tvalid_o);

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc, 3) && $past(s_tready_o, 2) && $past(s_tready_o, 1) |-> m_tvalid_o);

  // R8
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(m_tdata_o) &&
                                  $stable(m_tuser_o) && $stable(m_tlast_o));

  // R8
  stall_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |-> !s_tready_o);

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= 3'd3);

  // R8
  no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o |-> inflight_q != 3'd0);
endmodule

bind color_matrix_xform cmx_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_tvalid_i (s_tvalid_i),
  .s_tready_o (s_tready_o),
  .m_tdata_o  (m_tdata_o),
  .m_tvalid_o (m_tvalid_o),
  .m_tready_i (m_tready_i),
  .m_tuser_o  (m_tuser_o),
  .m_tlast_o  (m_tlast_o)
);

// File: tb/color_matrix_xform_tb.sv
`timescale 1ns/1ps
module color_matrix_xform_tb;
  typedef int mat_t [12];

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [3:0]  cfg_addr_i = '0;
  logic [17:0] cfg_data_i = '0;
  logic [23:0] s_tdata_i = '0;
  logic        s_tvalid_i = 0, s_tuser_i = 0, s_tlast_i = 0;
  logic        m_tready_i = 1;
  wire         s_tready_o, m_tvalid_o, m_tuser_o, m_tlast_o;
  wire  [23:0] m_tdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R2";
  logic [15:0] lfsr = 16'hACE1;
  int sh [12];
  int act [12];
  logic [23:0] q_d [$];
  bit q_u [$];
  bit q_l [$];

  always #2 clk = ~clk;

  color_matrix_xform u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_data_i(cfg_data_i), .s_tdata_i(s_tdata_i), .s_tvalid_i(s_tvalid_i),
    .s_tready_o(s_tready_o), .s_tuser_i(s_tuser_i), .s_tlast_i(s_tlast_i),
    .m_tdata_o(m_tdata_o), .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i),
    .m_tuser_o(m_tuser_o), .m_tlast_o(m_tlast_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [23:0] pix(input int i, input int salt);
    pix = {8'(i * 101 + 13 + salt), 8'(i * 37 + salt), 8'(i)};
  endfunction

  function automatic logic [23:0] model(input logic [23:0] d);
    logic [23:0] o;
    for (int r = 0; r < 3; r++) begin
      longint s = longint'(act[9 + r]) * 255;
      longint v;
      for (int k = 0; k < 3; k++) s += longint'(act[3 * r + k]) * longint'(d[8 * k +: 8]);
      v = (s + 32768) >>> 16;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      o[8 * r +: 8] = 8'(v);
    end
    return o;
  endfunction

  task automatic wr(input int a, input int v);
    @(negedge clk);
    cfg_we_i = 1; cfg_addr_i = 4'(a); cfg_data_i = 18'(v);
    if (a < 12) sh[a] = v;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic load(input mat_t m);
    for (int i = 0; i < 12; i++) wr(i, m[i]);
  endtask

  task automatic run_frame(input int npix, input bit sof_en, input int salt,
                           input bit full_rate);
    int sent = 0;
    int cyc = 0;
    bit hold = 0;
    bit stall_p = 0;
    logic [25:0] stall_v = '0;
    while ((sent < npix || q_d.size() > 0) && cyc < 8000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (sent < npix && (hold || full_rate || lfsr[0] || lfsr[3])) begin
        s_tvalid_i = 1;
        s_tdata_i  = pix(sent, salt);
        s_tuser_i  = sof_en && (sent == 0);
        s_tlast_i  = (sent == npix - 1);
      end else begin
        s_tvalid_i = 0; s_tuser_i = 0; s_tlast_i = 0;
      end
      m_tready_i = full_rate || lfsr[5] || lfsr[8];
      #1;
      if (stall_p)
        chk(m_tvalid_o && {m_tuser_o, m_tlast_o, m_tdata_o} == stall_v, "R8",
            "held output", {m_tvalid_o, m_tuser_o, m_tlast_o, m_tdata_o}, {1'b1, stall_v});
      if (s_tvalid_i && s_tready_o) begin
        if (s_tuser_i) act = sh;
        q_d.push_back(model(s_tdata_i));
        q_u.push_back(s_tuser_i);
        q_l.push_back(s_tlast_i);
        sent++;
        hold = 0;
      end else begin
        hold = s_tvalid_i;
      end
      if (m_tvalid_o && m_tready_i) begin
        if (q_d.size() == 0) begin
          chk(0, "R8", "extra pixel", m_tdata_o, 0);
        end else begin
          logic [23:0] e = q_d.pop_front();
          bit eu = q_u.pop_front();
          bit el = q_l.pop_front();
          chk(m_tdata_o == e, cur_req, "pixel", m_tdata_o, e);
          chk({m_tuser_o, m_tlast_o} == {eu, el}, "R7", "user/last",
              {m_tuser_o, m_tlast_o}, {eu, el});
        end
      end
      stall_p = m_tvalid_o && !m_tready_i;
      stall_v = {m_tuser_o, m_tlast_o, m_tdata_o};
    end
    @(negedge clk);
    s_tvalid_i = 0; s_tuser_i = 0; s_tlast_i = 0; m_tready_i = 1;
    chk(sent == npix && q_d.size() == 0, "R8", "all pixels delivered",
        sent, npix);
  endtask

  initial begin
    automatic mat_t ident = '{65536, 0, 0, 0, 65536, 0, 0, 0, 65536, 0, 0, 0};
    automatic mat_t swap  = '{0, 0, 65536, 0, 65536, 0, 65536, 0, 0, 0, 0, 0};
    automatic mat_t ycc   = '{19595, 38470, 7471, -11059, -21709, 32768,
                              32768, -27439, -5329, 0, 32768, 32768};
    automatic mat_t half  = '{32768, 0, 0, 0, -32768, 0, 0, 0, 98304, 0, 65536, 0};
    automatic mat_t sat   = '{131071, 131071, 0, -131072, 0, 0, 0, 0, 65536,
                              0, 65536, -65536};
    int cnt;
    sh = ident; act = ident;
    repeat (3) @(negedge clk);
    chk(m_tvalid_o == 0 && s_tready_o == 1, "R1", "reset outputs",
        {m_tvalid_o, s_tready_o}, 2'b01);
    rst_ni = 1;
    @(negedge clk);
    chk(m_tvalid_o == 0, "R1", "idle after reset", m_tvalid_o, 0);

    // R6: latency with ready high
    s_tvalid_i = 1; s_tdata_i = 24'h123456; s_tuser_i = 0; s_tlast_i = 0;
    @(negedge clk);
    s_tvalid_i = 0;
    cnt = 1;
    while (!m_tvalid_o && cnt < 10) begin @(negedge clk); cnt++; end
    chk(cnt == 3, "R6", "latency in edges", cnt, 3);
    chk(m_tdata_o == 24'h123456, "R1", "identity pass-through", m_tdata_o, 24'h123456);
    @(negedge clk);

    cur_req = "R1"; run_frame(256, 0, 0, 1);
    cur_req = "R1"; run_frame(256, 1, 5, 0);
    load(swap);   cur_req = "R10"; run_frame(256, 1, 1, 0);
    load(ycc);    cur_req = "R2";  run_frame(256, 1, 2, 0);
    load(half);   cur_req = "R3";  run_frame(256, 1, 3, 1);
    load(sat);    cur_req = "R4";  run_frame(256, 1, 4, 0);
    load(swap);   cur_req = "R10"; run_frame(16, 1, 6, 1);
    load(ycc);    cur_req = "R5";  run_frame(64, 0, 7, 0);
    cur_req = "R5"; run_frame(64, 1, 8, 0);
    wr(12, 65536); wr(13, -1); wr(14, 12345); wr(15, 131071);
    cur_req = "R9"; run_frame(64, 1, 9, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule